// File: doc/BRIEF.md
# Serial-Loaded Synthesizer Divider Register

This block is the programming front end of a frequency synthesizer's main divider. A controller drives three wires: a serial data line, a serial clock and a latch enable. Each rising serial clock edge pushes one data bit into an 18-bit shift register, most significant bit first. When the latch enable rises, the low bit of the shifted word chooses where the word goes. An address of 0 copies the upper 17 bits into the divider register. An address of 1 leaves the divider register alone and pulses a strobe that other logic can use.

The divider register holds three fields: a 10-bit main count, a 5-bit swallow count and a 2-bit control word made of a counter-reset request and a power-down request. The main count must be at least 3 and must not be smaller than the swallow count. The block flags a word that breaks either rule, but it still loads the word. All three serial wires are asynchronous to the system clock. Each passes through a two-flop synchronizer, and only rising edges of the serial clock and latch enable act.

Top module: `synth_ser_ctrl`

## Requirements
- R1: While rst is high and on the first cycle after it is released, the main count, swallow count, control outputs, invalid flag and strobe are all 0.
- R2: Each rising edge of the synchronized serial clock shifts the synchronized data bit into bit 0 of the 18-bit word, moving the older bits up one place, so the first bit sent ends in bit 17. A serial clock held high shifts only once, and bits sent more than 18 places back are lost.
- R3: The divider register changes only on a rising edge of the synchronized latch enable. Holding the latch enable high, lowering it, or shifting while it is high leaves the outputs unchanged.
- R4: On a latch edge with word bit 0 equal to 0, the register loads main count = word[17:8], swallow count = word[7:3], counter reset = word[2] and power down = word[1].
- R5: On a latch edge with word bit 0 equal to 1, every divider output and the invalid flag keep their values, and alt_stb_o is high for exactly one system clock cycle.
- R6: A loaded word whose main count is below 3, or below its swallow count, sets bad_cfg_o to 1. The fields are still loaded.
- R7: A loaded word with main count at least 3 and at least the swallow count clears bad_cfg_o. Equal main and swallow counts are legal.
- R8: Serial clock edges with no latch edge change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk_i | input | 1 | Serial bit clock (asynchronous) |
| ser_dat_i | input | 1 | Serial data bit (asynchronous) |
| ser_le_i | input | 1 | Latch enable (asynchronous) |
| main_cnt_o | output | 10 | Loaded main counter value |
| swal_cnt_o | output | 5 | Loaded swallow counter value |
| cnt_rst_o | output | 1 | Counter-reset request bit |
| pwr_dn_o | output | 1 | Power-down request bit |
| bad_cfg_o | output | 1 | Last loaded count pair is prohibited |
| alt_stb_o | output | 1 | One-cycle pulse on a latch with address 1 |

## Verification
The bench uses the default parameters: a 10-bit main field, a 5-bit swallow field, a minimum main count of 3 and two synchronizer stages. With these sizes every boundary can be reached in a few words. The full-scale counts 1023 and 31 are in reach, as are the illegal main counts 2 and 1, the legal floor of 3 with an equal swallow count, and a swallow count one above the main count. The short synchronizer keeps the latency from a pin to an output at three cycles. This lets the bench shift oversized words, hold the latch enable high across a shift, and mix both addresses within a short run.

// File: rtl/synth_ctrl_pkg.sv
package synth_ctrl_pkg;

  typedef enum logic {
    TGT_DIVIDER = 1'b0,
    TGT_OTHER   = 1'b1
  } target_e;

  // A count pair is prohibited when main is below the floor or below swallow.
  function automatic logic count_pair_bad(input int unsigned main_v,
                                          input int unsigned swal_v,
                                          input int unsigned floor_v);
    return (main_v < floor_v) || (main_v < swal_v);
  endfunction

endpackage

// File: rtl/synth_sync.sv
module synth_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout,
  output logic rise
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q[0] <= 1'b0;
    else     chain_q[0] <= din;
  end

  generate
    for (genvar g = 1; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain_q[g] <= 1'b0;
        else     chain_q[g] <= chain_q[g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= chain_q[STAGES-1];
  end

  assign dout = chain_q[STAGES-1];
  assign rise = dout & ~prev_q;

  // R2: an edge event lasts one cycle, so a held level acts once
  p_rise_single_r2: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise);

endmodule

// File: rtl/synth_shift.sv
module synth_shift #(
  parameter int WIDTH = 18
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             shift_en,
  input  logic             bit_in,
  output logic [WIDTH-1:0] word_o
);
  logic [WIDTH-1:0] sr_q;

  always_ff @(posedge clk) begin
    if (rst)           sr_q <= '0;
    else if (shift_en) sr_q <= {sr_q[WIDTH-2:0], bit_in};
  end

  assign word_o = sr_q;

  // R2: older bits move up one place on each shift event
  p_shift_move_r2: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> sr_q[WIDTH-1:1] == $past(sr_q[WIDTH-2:0]));

  // R2: no shift event, no change
  p_shift_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> $stable(sr_q));

endmodule

// File: rtl/synth_div_reg.sv
module synth_div_reg
  import synth_ctrl_pkg::*;
#(
  parameter int MAIN_W   = 10,
  parameter int SWAL_W   = 5,
  parameter int CTL_W    = 2,
  parameter int MIN_MAIN = 3,
  localparam int DIV_W   = MAIN_W + SWAL_W + CTL_W,
  localparam int WORD_W  = DIV_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_evt,
  input  logic [WORD_W-1:0] word_i,
  output logic [MAIN_W-1:0] main_o,
  output logic [SWAL_W-1:0] swal_o,
  output logic [CTL_W-1:0]  ctl_o,
  output logic              bad_o,
  output logic              alt_stb_o
);
  localparam int CTL_LO  = 1;
  localparam int SWAL_LO = CTL_LO + CTL_W;
  localparam int MAIN_LO = SWAL_LO + SWAL_W;

  target_e           tgt;
  logic [MAIN_W-1:0] w_main;
  logic [SWAL_W-1:0] w_swal;
  logic [CTL_W-1:0]  w_ctl;
  logic              div_wr;
  logic              alt_hit;
  logic              w_bad;

  assign tgt     = target_e'(word_i[0]);
  assign w_main  = word_i[MAIN_LO +: MAIN_W];
  assign w_swal  = word_i[SWAL_LO +: SWAL_W];
  assign w_ctl   = word_i[CTL_LO +: CTL_W];
  assign div_wr  = load_evt && (tgt == TGT_DIVIDER);
  assign alt_hit = load_evt && (tgt == TGT_OTHER);
  assign w_bad   = count_pair_bad(32'(w_main), 32'(w_swal), MIN_MAIN);

  always_ff @(posedge clk) begin
    if (rst) begin
      main_o <= '0;
      swal_o <= '0;
      ctl_o  <= '0;
      bad_o  <= 1'b0;
    end else if (div_wr) begin
      main_o <= w_main;
      swal_o <= w_swal;
      ctl_o  <= w_ctl;
      bad_o  <= w_bad;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) alt_stb_o <= 1'b0;
    else     alt_stb_o <= alt_hit;
  end

  // R4: an address-0 latch copies the upper word bits into the register
  p_load_fields_r4: assert property (@(posedge clk) disable iff (rst)
    (load_evt && !word_i[0]) |=>
      {main_o, swal_o, ctl_o} == $past(word_i[WORD_W-1:1]));

  // R6: a prohibited pair raises the flag
  p_flag_set_r6: assert property (@(posedge clk) disable iff (rst)
    (load_evt && !word_i[0] &&
     ((32'(word_i[WORD_W-1 -: MAIN_W]) < MIN_MAIN) ||
      (word_i[WORD_W-1 -: MAIN_W] < 10'(word_i[SWAL_LO +: SWAL_W])))) |=> bad_o);

  // R5: an address-1 latch leaves the register and flag alone and strobes
  p_alt_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (load_evt && word_i[0]) |=> ($stable({main_o, swal_o, ctl_o, bad_o}) && alt_stb_o));

  // R5: the strobe is a single-cycle pulse
  p_alt_single_r5: assert property (@(posedge clk) disable iff (rst)
    alt_stb_o |=> !alt_stb_o);

  // R3: without a latch event the register holds
  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !load_evt |=> $stable({main_o, swal_o, ctl_o, bad_o}));

endmodule

// File: rtl/synth_ser_ctrl.sv
module synth_ser_ctrl #(
  parameter int MAIN_W      = 10,
  parameter int SWAL_W      = 5,
  parameter int MIN_MAIN    = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_clk_i,
  input  logic              ser_dat_i,
  input  logic              ser_le_i,
  output logic [MAIN_W-1:0] main_cnt_o,
  output logic [SWAL_W-1:0] swal_cnt_o,
  output logic              cnt_rst_o,
  output logic              pwr_dn_o,
  output logic              bad_cfg_o,
  output logic              alt_stb_o
);
  localparam int CTL_W  = 2;
  localparam int WORD_W = MAIN_W + SWAL_W + CTL_W + 1;

  logic              sclk_lvl, sclk_rise;
  logic              sdat_lvl, sdat_rise;
  logic              le_lvl, le_rise;
  logic [WORD_W-1:0] word;
  logic [CTL_W-1:0]  ctl;

  synth_sync #(.STAGES(SYNC_STAGES)) u_sync_clk (
    .clk(clk), .rst(rst), .din(ser_clk_i), .dout(sclk_lvl), .rise(sclk_rise));

  synth_sync #(.STAGES(SYNC_STAGES)) u_sync_dat (
    .clk(clk), .rst(rst), .din(ser_dat_i), .dout(sdat_lvl), .rise(sdat_rise));

  synth_sync #(.STAGES(SYNC_STAGES)) u_sync_le (
    .clk(clk), .rst(rst), .din(ser_le_i), .dout(le_lvl), .rise(le_rise));

  synth_shift #(.WIDTH(WORD_W)) u_shift (
    .clk(clk), .rst(rst), .shift_en(sclk_rise), .bit_in(sdat_lvl), .word_o(word));

  synth_div_reg #(
    .MAIN_W(MAIN_W), .SWAL_W(SWAL_W), .CTL_W(CTL_W), .MIN_MAIN(MIN_MAIN)
  ) u_div (
    .clk(clk), .rst(rst), .load_evt(le_rise), .word_i(word),
    .main_o(main_cnt_o), .swal_o(swal_cnt_o), .ctl_o(ctl),
    .bad_o(bad_cfg_o), .alt_stb_o(alt_stb_o));

  assign cnt_rst_o = ctl[1];
  assign pwr_dn_o  = ctl[0];

  logic unused_ok;
  assign unused_ok = sdat_rise ^ le_lvl ^ sclk_lvl;

  // R1: the first cycle after reset shows the cleared state
  p_reset_clear_r1: assert property (@(posedge clk)
    $fell(rst) |-> (main_cnt_o == '0 && swal_cnt_o == '0 && !cnt_rst_o &&
                    !pwr_dn_o && !bad_cfg_o && !alt_stb_o));

  // R8: serial clock activity alone never disturbs the outputs
  p_shift_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    (sclk_rise && !le_rise) |=>
      $stable({main_cnt_o, swal_cnt_o, cnt_rst_o, pwr_dn_o, bad_cfg_o}));

endmodule

// File: tb/test_synth_ser_ctrl.sv
module test_synth_ser_ctrl;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst, ser_clk, ser_dat, ser_le;
  logic [9:0] main_cnt;
  logic [4:0] swal_cnt;
  logic       cnt_rst, pwr_dn, bad_cfg, alt_stb;

  synth_ser_ctrl i_synth_ser_ctrl (
    .clk(clk), .rst(rst), .ser_clk_i(ser_clk), .ser_dat_i(ser_dat), .ser_le_i(ser_le),
    .main_cnt_o(main_cnt), .swal_cnt_o(swal_cnt), .cnt_rst_o(cnt_rst),
    .pwr_dn_o(pwr_dn), .bad_cfg_o(bad_cfg), .alt_stb_o(alt_stb));

  typedef struct {
    int    main_v, swal_v, cr_v, pd_v, bad_v, stb_v;
    string req;
  } exp_t;

  exp_t q[$];
  event chk_ev;
  int n_chk = 0, n_fail = 0, stb_seen = 0;
  int m_main = 0, m_swal = 0, m_cr = 0, m_pd = 0, m_bad = 0;

  always @(negedge clk) if (alt_stb) stb_seen++;

  task automatic cmp(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(chk_ev);
      while (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        cmp(e.req, "main", int'(main_cnt), e.main_v);
        cmp(e.req, "swal", int'(swal_cnt), e.swal_v);
        cmp(e.req, "cnt_rst", int'(cnt_rst), e.cr_v);
        cmp(e.req, "pwr_dn", int'(pwr_dn), e.pd_v);
        cmp(e.req, "bad", int'(bad_cfg), e.bad_v);
        cmp(e.req, "strobe_cycles", stb_seen, e.stb_v);
        stb_seen = 0;
      end
    end
  end

  function automatic logic [17:0] mk(int mn, int sw, int cr, int pd, int ad);
    return {10'(mn), 5'(sw), 1'(cr), 1'(pd), 1'(ad)};
  endfunction

  task automatic expect_now(string req, int stb);
    exp_t e;
    e.main_v = m_main; e.swal_v = m_swal; e.cr_v = m_cr; e.pd_v = m_pd;
    e.bad_v = m_bad; e.stb_v = stb; e.req = req;
    q.push_back(e);
    -> chk_ev;
    @(negedge clk);
  endtask

  task automatic send_bit(logic b);
    @(negedge clk) ser_dat = b;
    repeat (3) @(negedge clk);
    ser_clk = 1'b1;
    repeat (4) @(negedge clk);
    ser_clk = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic shift_word(logic [17:0] w);
    for (int i = 17; i >= 0; i--) send_bit(w[i]);
  endtask

  task automatic le_pulse();
    @(negedge clk) ser_le = 1'b1;
    repeat (4) @(negedge clk);
    ser_le = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  // driver: model the expected effect of a latch of word w
  function automatic void model_latch(logic [17:0] w);
    if (!w[0]) begin
      m_main = int'(w[17:8]); m_swal = int'(w[7:3]);
      m_cr = int'(w[2]); m_pd = int'(w[1]);
      m_bad = (m_main < 3 || m_main < m_swal) ? 1 : 0;
    end
  endfunction

  task automatic load(logic [17:0] w, string req);
    shift_word(w);
    model_latch(w);
    le_pulse();
    expect_now(req, w[0] ? 1 : 0);
  endtask

  initial begin
    rst = 1'b1; ser_clk = 1'b0; ser_dat = 1'b0; ser_le = 1'b0;
    repeat (5) @(negedge clk);
    expect_now("R1", 0);
    rst = 1'b0;
    @(negedge clk);
    expect_now("R1", 0);

    load(mk(100, 7, 1, 0, 0), "R4");
    load(mk(2, 0, 0, 1, 0), "R6");
    load(mk(3, 3, 0, 0, 0), "R7");
    load(mk(5, 6, 1, 1, 0), "R6");
    load(mk(1023, 31, 1, 1, 0), "R4");
    load(mk(1, 9, 0, 0, 1), "R5");
    load(mk(1, 0, 0, 0, 0), "R6");
    load(mk(700, 0, 1, 1, 1), "R5");

    // R8: shift a word without latching
    shift_word(mk(64, 4, 0, 1, 0));
    expect_now("R8", 0);
    model_latch(mk(64, 4, 0, 1, 0));
    le_pulse();
    expect_now("R7", 0);

    // R2: two extra leading bits fall off the top
    send_bit(1'b1); send_bit(1'b1);
    shift_word(mk(12, 2, 0, 0, 0));
    model_latch(mk(12, 2, 0, 0, 0));
    le_pulse();
    expect_now("R2", 0);

    // R2: serial clock held high shifts one bit only
    shift_word(mk(40, 1, 1, 0, 0));
    @(negedge clk) ser_dat = 1'b0;
    ser_clk = 1'b1;
    repeat (30) @(negedge clk);
    ser_clk = 1'b0;
    repeat (4) @(negedge clk);
    model_latch({mk(40, 1, 1, 0, 0)} << 1);
    le_pulse();
    expect_now("R2", 0);

    // R3: latch enable held high across a new word, then lowered
    shift_word(mk(300, 20, 0, 1, 0));
    @(negedge clk) ser_le = 1'b1;
    model_latch(mk(300, 20, 0, 1, 0));
    repeat (8) @(negedge clk);
    expect_now("R3", 0);
    shift_word(mk(9, 0, 1, 0, 0));
    expect_now("R3", 0);
    ser_le = 1'b0;
    repeat (8) @(negedge clk);
    expect_now("R3", 0);
    le_pulse();
    model_latch(mk(9, 0, 1, 0, 0));
    expect_now("R3", 0);

    repeat (4) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule